// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Unit

This unit sits beside a processor core and decides when execution must stop for debugging. It watches two event sources. The first is the decode of the break opcode (00h), which the core reports with a one-cycle strobe. The second is every register-file access, which the core reports as an address, a data byte and read or write strobes.

When breakpoints are enabled, a decoded break opcode halts the core. When they are disabled, the unit tells the core to execute the opcode as a no-op. A single watchpoint compares each access against one programmed register address. It can be armed for reads, for writes or for both. It can also be limited to accesses that carry one exact data value.

A qualifying event is registered. On the next clock the unit raises a debug-mode request and an idle signal to the core. Both stay high until an external resume pulse arrives. A sticky source flag tells the debugger which path caused the most recent halt.

Top module: `dbg_trip_unit`

## Requirements
- R1: After synchronous reset, `dbg_req`, `cpu_idle` and `trip_src` are all 0.
- R2: While running, a `brk_dec` strobe with `brk_en`=1 makes `dbg_req` and `cpu_idle` 1 from the next rising edge onward.
- R3: `brk_nop` is 1 in the same cycle exactly when `brk_dec`=1 and `brk_en`=0. Such a strobe never causes a halt.
- R4: While running, an access whose address equals `wp_addr` causes a halt on the next edge in two cases: it is a read (`acc_rd`=1) with `wp_on_rd`=1, or it is a write (`acc_wr`=1) with `wp_on_wr`=1.
- R5: An access whose direction flag is clear never triggers. With `wp_on_rd`=0 and `wp_on_wr`=0 the watchpoint never triggers.
- R6: With `wp_data_qual`=1, a watchpoint trigger also requires `acc_data`==`wp_data`. With `wp_data_qual`=0 the data value is ignored.
- R7: An access whose address differs from `wp_addr` never triggers.
- R8: Once halted, `dbg_req` and `cpu_idle` stay 1 until a cycle with `resume`=1. They are 0 from the next edge after that cycle. `resume` while running has no effect.
- R9: Break or watchpoint events that arrive while halted are ignored. They change neither `trip_src` nor the halt.
- R10: `trip_src` is updated only at halt entry: 0 for the breakpoint, 1 for the watchpoint. The breakpoint wins when both events occur in the same cycle. The value is kept after resume.
- R11: `cpu_idle` always equals `dbg_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_dec | input | 1 | Break opcode decoded this cycle |
| brk_en | input | 1 | Breakpoints enabled |
| acc_addr | input | ADDR_W (12) | Register-file access address |
| acc_data | input | DATA_W (8) | Register-file access data |
| acc_rd | input | 1 | Read access strobe |
| acc_wr | input | 1 | Write access strobe |
| wp_addr | input | ADDR_W (12) | Watchpoint address |
| wp_data | input | DATA_W (8) | Watchpoint compare value |
| wp_on_rd | input | 1 | Watchpoint armed for reads |
| wp_on_wr | input | 1 | Watchpoint armed for writes |
| wp_data_qual | input | 1 | Require a data match |
| resume | input | 1 | Leave debug mode |
| dbg_req | output | 1 | Debug-mode entry request |
| cpu_idle | output | 1 | Stall the core |
| brk_nop | output | 1 | Execute the break opcode as a no-op |
| trip_src | output | 1 | Source of the last halt (0 break, 1 watchpoint) |

## Verification
`brk_nop` is combinational. The bench samples it one time unit after the inputs change, within the same cycle. `dbg_req`, `cpu_idle` and `trip_src` come from one register stage. The bench therefore compares them with its model one time unit after the rising edge that closes the stimulus cycle, and the model advances its state at that same edge. Every directed and random step checks both timing points, so a result that appears a cycle early or a cycle late is reported.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    // Source of the most recent halt
    typedef enum logic {
        SRC_BREAK = 1'b0,
        SRC_WATCH = 1'b1
    } trip_src_e;

    // Run state of the debug controller
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } dbg_state_e;

    // Watchpoint qualification mode
    typedef struct packed {
        logic on_rd;
        logic on_wr;
        logic data_qual;
    } wp_mode_t;

    // Event summary handed from the detectors to the controller
    typedef struct packed {
        logic brk;
        logic wp;
    } trip_evt_t;

    // True when the access direction is one the watchpoint is armed for
    function automatic logic dir_hit(wp_mode_t m, logic rd, logic wr);
        return (m.on_rd && rd) || (m.on_wr && wr);
    endfunction

    // Priority pick of the halt source: breakpoint first
    function automatic trip_src_e pick_src(trip_evt_t e);
        return e.brk ? SRC_BREAK : SRC_WATCH;
    endfunction

endpackage

// File: rtl/dbg_brk_gate.sv
module dbg_brk_gate
    import dbg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic brk_dec,
    input  logic brk_en,
    output logic brk_trig,
    output logic brk_nop
);

    // Enabled break opcode requests a halt
    assign brk_trig = brk_dec && brk_en;

    // Disabled break opcode degrades to a no-op
    assign brk_nop  = brk_dec && !brk_en;

    AST_NOP_NOT_TRIG: assert property (@(posedge clk) disable iff (rst)
        brk_nop |-> !brk_trig);  // R3

    AST_NOP_NEEDS_DEC: assert property (@(posedge clk) disable iff (rst)
        brk_nop |-> brk_dec);  // R3

endmodule

// File: rtl/dbg_wp_match.sv
module dbg_wp_match
    import dbg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_data,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] wp_addr,
    input  logic [DATA_W-1:0] wp_data,
    input  wp_mode_t          mode,
    output logic              wp_hit
);

    localparam int NIB_W   = 4;
    localparam int NIBBLES = (DATA_W + NIB_W - 1) / NIB_W;
    localparam int PAD_W   = NIBBLES * NIB_W;

    logic [PAD_W-1:0]   data_a;
    logic [PAD_W-1:0]   data_b;
    logic [NIBBLES-1:0] nib_eq;
    logic               addr_eq;
    logic               data_ok;
    logic               dir_ok;

    assign data_a = PAD_W'(acc_data);
    assign data_b = PAD_W'(wp_data);

    // Data compare split into nibble lanes, reduced below
    for (genvar g = 0; g < NIBBLES; g++) begin : g_lane
        assign nib_eq[g] = (data_a[g*NIB_W +: NIB_W] == data_b[g*NIB_W +: NIB_W]);
    end

    assign addr_eq = (acc_addr == wp_addr);
    assign data_ok = !mode.data_qual || (&nib_eq);
    assign dir_ok  = dir_hit(mode, acc_rd, acc_wr);
    assign wp_hit  = addr_eq && data_ok && dir_ok;

    AST_WP_NEEDS_ADDR: assert property (@(posedge clk) disable iff (rst)
        wp_hit |-> (acc_addr == wp_addr));  // R7

    AST_WP_OFF: assert property (@(posedge clk) disable iff (rst)
        (!mode.on_rd && !mode.on_wr) |-> !wp_hit);  // R5

    AST_WP_DATA: assert property (@(posedge clk) disable iff (rst)
        (wp_hit && mode.data_qual) |-> (acc_data == wp_data));  // R6

endmodule

// File: rtl/dbg_ctl.sv
module dbg_ctl
    import dbg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trip_evt_t evt,
    input  logic      resume,
    output logic      halted,
    output trip_src_e src
);

    dbg_state_e state_q, state_d;
    trip_src_e  src_q, src_d;
    logic       enter;

    assign enter = (state_q == ST_RUN) && (evt.brk || evt.wp);

    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            ST_RUN: begin
                if (enter) begin
                    state_d = ST_HALT;
                    src_d   = pick_src(evt);
                end
            end
            ST_HALT: begin
                if (resume) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            src_q   <= SRC_BREAK;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    assign halted = (state_q == ST_HALT);
    assign src    = src_q;

    AST_ENTRY_NEXT: assert property (@(posedge clk) disable iff (rst)
        (!halted && (evt.brk || evt.wp)) |=> halted);  // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!halted && !evt.brk && !evt.wp) |=> !halted);  // R8

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (halted && !resume) |=> halted);  // R8

    AST_EXIT: assert property (@(posedge clk) disable iff (rst)
        (halted && resume) |=> !halted);  // R8

    AST_SRC_KEEP: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(src));  // R9

    AST_BRK_PRIO: assert property (@(posedge clk) disable iff (rst)
        (!halted && evt.brk) |=> (src == SRC_BREAK));  // R10

endmodule

// File: rtl/dbg_trip_unit.sv
module dbg_trip_unit
    import dbg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              brk_dec,
    input  logic              brk_en,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_data,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] wp_addr,
    input  logic [DATA_W-1:0] wp_data,
    input  logic              wp_on_rd,
    input  logic              wp_on_wr,
    input  logic              wp_data_qual,
    input  logic              resume,
    output logic              dbg_req,
    output logic              cpu_idle,
    output logic              brk_nop,
    output logic              trip_src
);

    wp_mode_t  mode;
    trip_evt_t evt;
    logic      halted;
    trip_src_e src;

    assign mode = '{on_rd: wp_on_rd, on_wr: wp_on_wr, data_qual: wp_data_qual};

    dbg_brk_gate u_brk (
        .clk      (clk),
        .rst      (rst),
        .brk_dec  (brk_dec),
        .brk_en   (brk_en),
        .brk_trig (evt.brk),
        .brk_nop  (brk_nop)
    );

    dbg_wp_match #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_wp (
        .clk      (clk),
        .rst      (rst),
        .acc_addr (acc_addr),
        .acc_data (acc_data),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .wp_addr  (wp_addr),
        .wp_data  (wp_data),
        .mode     (mode),
        .wp_hit   (evt.wp)
    );

    dbg_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .resume (resume),
        .halted (halted),
        .src    (src)
    );

    assign dbg_req  = halted;
    assign cpu_idle = halted;
    assign trip_src = (src == SRC_WATCH);

    AST_IDLE_TRACKS: assert property (@(posedge clk) disable iff (rst)
        cpu_idle == dbg_req);  // R11

    AST_DISABLED_BRK: assert property (@(posedge clk) disable iff (rst)
        (!dbg_req && brk_nop && !evt.wp) |=> !dbg_req);  // R3

endmodule

// File: tb/tb_dbg_trip_unit.sv
module tb_dbg_trip_unit;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              brk_dec, brk_en, acc_rd, acc_wr;
    logic              wp_on_rd, wp_on_wr, wp_data_qual, resume;
    logic [ADDR_W-1:0] acc_addr, wp_addr;
    logic [DATA_W-1:0] acc_data, wp_data;
    logic              dbg_req, cpu_idle, brk_nop, trip_src;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model state
    logic m_halt = 1'b0;
    logic m_src  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_trip_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .brk_dec(brk_dec), .brk_en(brk_en),
        .acc_addr(acc_addr), .acc_data(acc_data), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .wp_addr(wp_addr), .wp_data(wp_data), .wp_on_rd(wp_on_rd), .wp_on_wr(wp_on_wr),
        .wp_data_qual(wp_data_qual), .resume(resume),
        .dbg_req(dbg_req), .cpu_idle(cpu_idle), .brk_nop(brk_nop), .trip_src(trip_src)
    );

    function automatic logic exp_wp();
        logic dir;
        dir = (wp_on_rd && acc_rd) || (wp_on_wr && acc_wr);
        return dir && (acc_addr == wp_addr) && (!wp_data_qual || acc_data == wp_data);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        brk_dec = 0; acc_rd = 0; acc_wr = 0; resume = 0;
    endtask

    // One cycle: inputs already driven; check comb output, clock, check state
    task automatic step(input string tag);
        logic bk, wp;
        #1;
        check("R3", brk_nop, brk_dec && !brk_en);
        bk = brk_dec && brk_en;
        wp = exp_wp();
        if (!m_halt) begin
            if (bk || wp) begin
                m_halt = 1'b1;
                m_src  = bk ? 1'b0 : 1'b1;
            end
        end else if (resume) begin
            m_halt = 1'b0;
        end
        @(posedge clk);
        #1;
        check(tag, dbg_req, m_halt);
        check("R11", cpu_idle, dbg_req);
        check("R10", trip_src, m_src);
    endtask

    task automatic do_resume();
        idle_inputs(); resume = 1; step("R8");
        idle_inputs(); step("R8");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; idle_inputs(); brk_en = 0;
        acc_addr = 0; acc_data = 0; wp_addr = 12'h3A5; wp_data = 8'h5C;
        wp_on_rd = 0; wp_on_wr = 0; wp_data_qual = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", dbg_req, 1'b0);
        check("R1", cpu_idle, 1'b0);
        check("R1", trip_src, 1'b0);
        rst = 0;

        // R3: disabled break is a no-op and does not halt
        brk_dec = 1; brk_en = 0; step("R3");
        // R8: resume while running has no effect
        idle_inputs(); resume = 1; step("R8");
        // R2: enabled break halts on next edge
        idle_inputs(); brk_en = 1; brk_dec = 1; step("R2");
        // R8: hold while no resume
        idle_inputs(); step("R8"); step("R8");
        do_resume();

        // R5: watchpoint off, matching access ignored
        acc_addr = wp_addr; acc_rd = 1; step("R5");
        // R5: only write armed, read ignored
        idle_inputs(); wp_on_wr = 1; acc_addr = wp_addr; acc_rd = 1; step("R5");
        // R7: address mismatch write
        idle_inputs(); acc_addr = wp_addr ^ 12'h001; acc_wr = 1; step("R7");
        // R4: matching write triggers, source watchpoint
        idle_inputs(); acc_addr = wp_addr; acc_wr = 1; step("R4");
        // R9: break while halted ignored, source kept
        idle_inputs(); brk_dec = 1; step("R9");
        do_resume();
        // R4: read armed, read triggers
        wp_on_rd = 1; wp_on_wr = 0; acc_addr = wp_addr; acc_rd = 1; step("R4");
        do_resume();
        // R6: data qualifier, wrong value ignored, right value triggers
        wp_data_qual = 1; acc_addr = wp_addr; acc_rd = 1; acc_data = wp_data ^ 8'h80; step("R6");
        idle_inputs(); acc_addr = wp_addr; acc_rd = 1; acc_data = wp_data; step("R6");
        do_resume();
        // R10: simultaneous break and watchpoint, breakpoint wins
        brk_dec = 1; acc_addr = wp_addr; acc_rd = 1; acc_data = wp_data; step("R10");
        do_resume();
        // R10: source retained after resume (checked in step)
        idle_inputs(); step("R10");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r;
            idle_inputs();
            r = 4'($urandom);
            if (r == 0) begin
                wp_on_rd = 1'($urandom); wp_on_wr = 1'($urandom);
                wp_data_qual = 1'($urandom); brk_en = 1'($urandom);
                wp_data = DATA_W'($urandom % 4);
            end
            brk_dec  = ($urandom % 8) == 0;
            acc_rd   = 1'($urandom);
            acc_wr   = !acc_rd && 1'($urandom);
            acc_addr = (($urandom % 3) == 0) ? ADDR_W'($urandom) : wp_addr;
            acc_data = DATA_W'($urandom % 4);
            resume   = ($urandom % 4) == 0;
            if (brk_dec && brk_en) step("R2");
            else if (exp_wp()) step(wp_data_qual ? "R6" : "R4");
            else if (m_halt) step("R9");
            else step("R5");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule